// File: doc/BRIEF.md
# Core Voltage Regulator Start-Up Sequencer

This block is the control state machine of a multiphase core-voltage regulator. It watches three digitised enable conditions: bias power-on-reset, the power-rail enable comparator and the termination-rail enable comparator. While any of them is low, it keeps every PWM output in the high-impedance state. Once all three are high, it starts a soft-start toward a fixed boot reference. It waits at that level for a programmable dwell and then reads the processor VID code. A valid code becomes the regulation target. An OFF code latches the regulator off until an enable is cycled.

The reference target is an 8-bit code in which each step is 6.25 mV and a larger code means a lower voltage. The boot level is 1.1 V, code 0x52. The block never jumps to a new VID. It moves the target one code per programmable interval until the target equals the requested code. While it is moving, it flags the protection logic to widen the overcurrent limit to 140% and to use the highest overvoltage trip level. It keeps a requested low-power mode inactive during the move and for a programmable hold-off after it. The ready output follows the output-in-window flag, but only while the block is regulating.

Top module: `vr_startup_seq`

## Requirements
- R1: The block leaves shutdown only when bias_ok, pwr_en_ok and vtt_en_ok are all high at one clock edge; any two of the three keep it in shutdown.
- R2: In shutdown and in the latched-off state, pwm_hiz is 1. In shutdown, target_code reads 0x00.
- R3: On the edge that leaves shutdown, target_code becomes the boot code 0x52. The VID inputs are ignored until soft_start_done is seen.
- R4: After soft_start_done, the block dwells at the boot code for exactly DWELL_CYC cycles and then samples vid_code once.
- R5: The codes 0x00, 0x01, 0xFE and 0xFF are OFF codes. An OFF code sampled after the dwell enters a latched-off state that ignores later VID values. Only a fall and rise of any enable clears this state and starts a new soft-start.
- R6: In regulation, target_code moves by exactly one code every STEP_CYC cycles toward the latest valid vid_code. The first step comes STEP_CYC cycles after the new code is taken. An OFF code seen during regulation leaves the target unchanged.
- R7: vr_ready is 1 only while regulating, with out_in_window high and all enables high.
- R8: ocp_widen and ovp_max are both 1 exactly while a regulating target differs from the requested code.
- R9: lowpwr_active follows lowpwr_req only while regulating with no change in progress, and only once HOLD_CYC cycles have passed since the last change ended.
- R10: If any enable falls, vr_ready drops in the same cycle, and the block is in shutdown after the next edge.
- R11: A synchronous active-low reset places the block in shutdown with target_code 0x00 and vr_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bias_ok | input | 1 | Bias supply above its power-on-reset threshold |
| pwr_en_ok | input | 1 | Power-rail enable comparator result |
| vtt_en_ok | input | 1 | Termination-rail enable comparator result |
| vid_code | input | CODE_W | Processor VID code |
| soft_start_done | input | 1 | Output has reached the soft-start target |
| out_in_window | input | 1 | Output is inside its regulation window |
| lowpwr_req | input | 1 | Processor low-power mode request |
| target_code | output | CODE_W | Reference target code for the DAC |
| pwm_hiz | output | 1 | Request high impedance on all PWM outputs |
| vr_ready | output | 1 | Regulator ready |
| ocp_widen | output | 1 | Raise the overcurrent limit to 140% |
| ovp_max | output | 1 | Select the maximum overvoltage trip level |
| lowpwr_active | output | 1 | Low-power mode granted to the power stage |

## Verification
The bench pins down the exact edge on which the VID is first sampled. A sequencer that reads it one cycle early or late shows the widen flags on the wrong cycle. The bench also times the first target step after the dwell, so a stepper that jumps straight to the VID or waits an extra interval fails the step-timing checks. It sends OFF codes both after the boot dwell and during regulation. A design that latches off on the wrong one, or clears the latch when the VID changes instead of when an enable is cycled, leaves pwm_hiz in the wrong state. Finally, it counts the low-power hold-off cycle by cycle after a transition, which catches a design that re-enters low-power mode as soon as the target settles.

// File: rtl/vr_seq_pkg.sv
package vr_seq_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_SHUT  = 3'd0,   // drivers off, waiting for all enables
        ST_SOFT  = 3'd1,   // ramping to boot level
        ST_DWELL = 3'd2,   // holding at boot level
        ST_REG   = 3'd3,   // regulating to VID (stepping when needed)
        ST_LATCH = 3'd4    // OFF code seen, wait for enable cycle
    } seq_state_e;

endpackage

// File: rtl/vr_vid_decode.sv
module vr_vid_decode #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code,
    output logic              is_off
);
    localparam logic [CODE_W-1:0] ALL_ONES = '1;

    always_comb begin
        is_off = (code == '0) || (code == CODE_W'(1)) ||
                 (code == ALL_ONES) || (code == ALL_ONES - CODE_W'(1));
    end
endmodule

// File: rtl/vr_lp_holdoff.sv
module vr_lp_holdoff #(
    parameter int HOLD_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,     // not regulating: forget any hold-off
    input  logic busy,    // VID change in progress
    output logic quiet    // hold-off expired
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (busy) begin
            cnt_d = HW'(HOLD_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - HW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign quiet = (cnt_q == '0);
endmodule

// File: rtl/vr_startup_seq.sv
module vr_startup_seq
    import vr_seq_pkg::*;
#(
    parameter int                CODE_W    = 8,
    parameter logic [CODE_W-1:0] BOOT_CODE = 8'h52,
    parameter int                DWELL_CYC = 20000,
    parameter int                STEP_CYC  = 200,
    parameter int                HOLD_CYC  = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bias_ok,
    input  logic              pwr_en_ok,
    input  logic              vtt_en_ok,
    input  logic [CODE_W-1:0] vid_code,
    input  logic              soft_start_done,
    input  logic              out_in_window,
    input  logic              lowpwr_req,
    output logic [CODE_W-1:0] target_code,
    output logic              pwm_hiz,
    output logic              vr_ready,
    output logic              ocp_widen,
    output logic              ovp_max,
    output logic              lowpwr_active
);
    localparam int TMR_MAX = (DWELL_CYC > STEP_CYC) ? DWELL_CYC : STEP_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CODE_W-1:0] tgt;
        logic [CODE_W-1:0] goal;
        logic [TMR_W-1:0]  tmr;
    } seq_regs_t;

    localparam seq_regs_t RST_VAL = '{st: ST_SHUT, tgt: '0, goal: '0, tmr: '0};

    seq_regs_t d, q;
    logic      all_en, vid_off, stepping, regulating, lp_quiet;

    assign all_en     = bias_ok && pwr_en_ok && vtt_en_ok;
    assign regulating = (q.st == ST_REG);
    assign stepping   = regulating && (q.tgt != q.goal);

    vr_vid_decode #(.CODE_W(CODE_W)) u_dec (
        .code   (vid_code),
        .is_off (vid_off)
    );

    vr_lp_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!regulating),
        .busy  (stepping),
        .quiet (lp_quiet)
    );

    always_comb begin
        d = q;
        if (!all_en) begin
            d = RST_VAL;
        end else begin
            case (q.st)
                ST_SHUT: begin
                    d.st   = ST_SOFT;
                    d.tgt  = BOOT_CODE;
                    d.goal = BOOT_CODE;
                    d.tmr  = '0;
                end
                ST_SOFT: begin
                    if (soft_start_done) begin
                        d.st  = ST_DWELL;
                        d.tmr = TMR_W'(DWELL_CYC - 1);
                    end
                end
                ST_DWELL: begin
                    if (q.tmr == '0) begin
                        if (vid_off) begin
                            d.st = ST_LATCH;
                        end else begin
                            d.st   = ST_REG;
                            d.goal = vid_code;
                            d.tmr  = TMR_W'(STEP_CYC - 1);
                        end
                    end else begin
                        d.tmr = q.tmr - TMR_W'(1);
                    end
                end
                ST_REG: begin
                    if (!vid_off) d.goal = vid_code;
                    if (q.tgt != q.goal) begin
                        if (q.tmr == '0) begin
                            d.tgt = (q.goal > q.tgt) ? q.tgt + CODE_W'(1)
                                                     : q.tgt - CODE_W'(1);
                            d.tmr = TMR_W'(STEP_CYC - 1);
                        end else begin
                            d.tmr = q.tmr - TMR_W'(1);
                        end
                    end else begin
                        d.tmr = TMR_W'(STEP_CYC - 1);
                    end
                end
                ST_LATCH: begin
                    d = q;
                end
                default: d = RST_VAL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    assign target_code   = q.tgt;
    assign pwm_hiz       = (q.st == ST_SHUT) || (q.st == ST_LATCH);
    assign vr_ready      = regulating && out_in_window && all_en;
    assign ocp_widen     = stepping;
    assign ovp_max       = stepping;
    assign lowpwr_active = lowpwr_req && regulating && !stepping && lp_quiet && all_en;
endmodule

// File: rtl/vr_startup_seq_chk.sv
module vr_startup_seq_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bias_ok,
    input logic              pwr_en_ok,
    input logic              vtt_en_ok,
    input logic [CODE_W-1:0] vid_code,
    input logic              soft_start_done,
    input logic              out_in_window,
    input logic              lowpwr_req,
    input logic [CODE_W-1:0] target_code,
    input logic              pwm_hiz,
    input logic              vr_ready,
    input logic              ocp_widen,
    input logic              ovp_max,
    input logic              lowpwr_active
);
    a_r2_hiz_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(bias_ok && pwr_en_ok && vtt_en_ok) |=> pwm_hiz);

    a_r7_ready_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        vr_ready |-> (out_in_window && !pwm_hiz));

    a_r8_flags_paired: assert property (@(posedge clk) disable iff (!rst_n)
        ocp_widen == ovp_max);

    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ocp_widen |=> (pwm_hiz ||
                       target_code == $past(target_code) ||
                       target_code == CODE_W'($past(target_code) + CODE_W'(1)) ||
                       target_code == CODE_W'($past(target_code) - CODE_W'(1))));

    a_r9_lowpwr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr_active |-> (lowpwr_req && !ocp_widen && !pwm_hiz));

    a_r10_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(bias_ok && pwr_en_ok && vtt_en_ok) |-> !vr_ready);
endmodule

bind vr_startup_seq vr_startup_seq_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/vr_startup_seq_bench.sv
`timescale 1ns/100ps
module vr_startup_seq_bench;
    localparam int D = 8;
    localparam int S = 2;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bias_ok = 1'b0, pwr_en_ok = 1'b0, vtt_en_ok = 1'b0;
    logic [7:0] vid_code = 8'h30;
    logic       soft_start_done = 1'b0, out_in_window = 1'b0, lowpwr_req = 1'b0;
    logic [7:0] target_code;
    logic       pwm_hiz, vr_ready, ocp_widen, ovp_max, lowpwr_active;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    vr_startup_seq #(.CODE_W(8), .BOOT_CODE(8'h52), .DWELL_CYC(D),
                     .STEP_CYC(S), .HOLD_CYC(H)) u_vr_startup_seq (.*);

    // {requested vid, expected settled target}
    localparam logic [15:0] VEC_TAB [0:4] = '{
        16'h34_34, 16'h2E_2E, 16'hFF_2E, 16'h60_60, 16'h01_60
    };

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #1;
        tick(2);
        // R11 reset state
        chk("R11 hiz", pwm_hiz, 1);
        chk("R11 target", target_code, 8'h00);
        chk("R11 ready", vr_ready, 0);
        rst_n = 1'b1;
        // R1 partial enables
        bias_ok = 1; pwr_en_ok = 1;
        tick(5);
        chk("R1 two enables", pwm_hiz, 1);
        pwr_en_ok = 0; vtt_en_ok = 1;
        tick(3);
        chk("R1 bias+vtt", pwm_hiz, 1);
        chk("R2 shutdown target", target_code, 8'h00);
        pwr_en_ok = 1; out_in_window = 1;
        tick(1);
        chk("R1 leave shutdown", pwm_hiz, 0);
        chk("R3 boot code", target_code, 8'h52);
        tick(3);
        chk("R3 vid ignored", target_code, 8'h52);
        chk("R7 not ready in soft-start", vr_ready, 0);
        // R4 dwell timing
        soft_start_done = 1;
        tick(1);
        tick(D - 1);
        chk("R4 still dwelling", ocp_widen, 0);
        tick(1);
        chk("R4 sampled", ocp_widen, 1);
        chk("R8 ovp flag", ovp_max, 1);
        chk("R6 no jump", target_code, 8'h52);
        tick(S - 1);
        chk("R6 before step", target_code, 8'h52);
        tick(1);
        chk("R6 first step", target_code, 8'h51);
        tick(80);
        chk("R6 settled", target_code, 8'h30);
        chk("R8 flags clear", ocp_widen, 0);
        chk("R7 ready", vr_ready, 1);
        out_in_window = 0; #1;
        chk("R7 out of window", vr_ready, 0);
        out_in_window = 1; #1;
        // table of VID changes during regulation
        for (int i = 0; i < 5; i++) begin
            vid_code = VEC_TAB[i][15:8];
            tick(120);
            chk("R6 table", target_code, {24'd0, VEC_TAB[i][7:0]});
        end
        // R9 low-power hold-off
        lowpwr_req = 1;
        tick(1);
        chk("R9 granted when idle", lowpwr_active, 1);
        vid_code = 8'h5C;
        tick(1);
        chk("R9 blocked in change", lowpwr_active, 0);
        for (int k = 0; k < 50; k++) begin
            if (target_code == 8'h5C) break;
            tick(1);
        end
        chk("R9 settled at 0x5C", target_code, 8'h5C);
        chk("R9 hold-off start", lowpwr_active, 0);
        tick(H - 1);
        chk("R9 hold-off end-1", lowpwr_active, 0);
        tick(1);
        chk("R9 hold-off done", lowpwr_active, 1);
        // R10 enable drop
        vtt_en_ok = 0; #1;
        chk("R10 ready same cycle", vr_ready, 0);
        tick(1);
        chk("R10 shutdown", pwm_hiz, 1);
        chk("R2 target cleared", target_code, 8'h00);
        // R5 OFF code latch
        vid_code = 8'hFE; vtt_en_ok = 1;
        tick(2 + D + 1);
        chk("R5 latched off", pwm_hiz, 1);
        vid_code = 8'h40;
        tick(20);
        chk("R5 vid does not clear", pwm_hiz, 1);
        pwr_en_ok = 0;
        tick(1);
        pwr_en_ok = 1;
        tick(1);
        chk("R5 restart", pwm_hiz, 0);
        tick(1 + D);
        chk("R5 valid after restart", ocp_widen, 1);
        // R11 reset mid-run
        rst_n = 0;
        tick(1);
        chk("R11 reset hiz", pwm_hiz, 1);
        chk("R11 reset target", target_code, 8'h00);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule